// File: doc/BRIEF.md
# SCSI Host Adapter Command and Interrupt Register Front End

This block is the byte-wide register front end of a simple SCSI host adapter. Software writes and reads single bytes at a 4-bit address. A write to the command register is decoded at once: it updates the status, interrupt-cause and sequence-step registers, can reload the 24-bit transfer counter, and can raise one level-sensitive interrupt line. The block does no bus signalling and moves no data. For the three selection commands it pulses a start strobe with a mode code, which an external bus sequencer acts on.

Reading the interrupt-cause register acknowledges the interrupt. The read returns the cause byte in the same cycle. On that clock edge the block clears the cause, clears the terminal-count status bit, sets the sequence step to the command-done value and drops the interrupt line. A small FIFO fill counter stands in for the data FIFO, so the flush and message-accept commands have a visible effect through the flags register. The transfer-counter high byte doubles as a chip identity until software first writes it.

Register map (read data is combinational from the address): 0/1/2 transfer counter low/mid/high (write the load copy, read the working value); 3 FIFO data (a write counts one byte, a read returns 0); 4 command (a read returns the last accepted command byte); 5 status (read only); 6 interrupt cause (read to clear); 7 sequence step; 8 FIFO flags; 9 configuration 1 (read/write). Any other address reads 0 and ignores writes.

Top module: `scsi_cmd_regs`

## Requirements
- R1: The `irq` output rises only on the clock edge that accepts a command that raises an interrupt, and falls only on an acknowledge read of address 6 or on a hard reset. Status bit 7 always reads equal to `irq`.
- R2: A read of address 6 (with `wr_en` low) returns the current cause byte in the same cycle. On that edge the cause becomes 0x00, status bit 4 (terminal count) clears, the sequence step (address 7) becomes 4 and `irq` goes low.
- R3: Writing a known command with bit 7 (DMA flag) set copies the three written counter bytes into the readable counter registers at addresses 0–2. With bit 7 clear, status bit 4 is cleared instead. A counter write alone does not change what addresses 0–2 read. Command 0x00 (nop) has only these effects.
- R4: Address 2 reads the identity value 0xA2 until address 2 has been written after the last hard reset. After that it reads the working high byte.
- R5: Command 0x01 (flush) sets the FIFO count (address 8) to 0, the cause to 0x08 (function complete) and the sequence step to 0, and raises `irq`.
- R6: Command 0x03 (bus reset) sets the cause to 0x80. It raises `irq` only if bit 6 of configuration 1 (address 9) is clear; otherwise `irq` is unchanged.
- R7: Command 0x11 (initiator complete) sets the cause to 0x08, sets status bits 2:0 to 111 (message-in phase) and raises `irq`.
- R8: Command 0x12 (message accept) sets the cause to 0x20 (disconnect) and sets the sequence step and the FIFO count to 0. It raises `irq`.
- R9: Command 0x18 (transfer pad) makes status read exactly 0x90 (terminal count plus interrupt, phase 0), sets the cause to 0x08 and the sequence step to 0, and raises `irq`.
- R10: Either `rst_n` low at a clock edge or command 0x02 (chip reset) clears every register to zero, loads configuration 1 with 0x07, lowers `irq`, clears `sel_start` and `sel_mode` and re-arms the identity read of R4. The command register then reads 0x00.
- R11: Commands 0x41, 0x42 and 0x43 pulse `sel_start` high for the one cycle after the write edge. In that cycle `sel_mode` is 0, 1 or 2 respectively and it holds that value afterwards. Commands 0x44 and 0x45 set the cause to 0x00 and leave `irq` unchanged.
- R12: A command byte whose low seven bits are not one of the codes above changes nothing, including the counter reload and the terminal-count clear, and is not recorded in the command register.
- R13: Each write to address 3 adds one to the FIFO count read at address 8. The count saturates at 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Read strobe; only matters for the acknowledge read of address 6 |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |
| sel_start | output | 1 | One-cycle selection start strobe |
| sel_mode | output | 2 | Selection kind: 0 plain, 1 with attention, 2 with attention and stop |

## Verification
Each command is issued twice: once with the DMA flag set and once with it clear. This separates the counter reload from the terminal-count clear, and a counter write with no reload shows the two register copies are distinct. Bus reset is issued with the suppress bit clear and then set, and the pending-interrupt state differs between those cases, so the gating of the line is told apart from the setting of the cause. An unknown code with the DMA flag set, and enable-selection with an interrupt pending, show that one leaves all state alone and the other clears only the cause. A run of FIFO writes past the depth, followed by flush, message accept and chip reset, covers the count saturation and the identity re-arm.

// File: rtl/scsi_regs_pkg.sv
// Shared constants and types for the SCSI command/interrupt register front end.
// Assumes a 4-bit byte address space and an 8-bit command byte.
package scsi_regs_pkg;
    localparam int CNT_BYTES = 3;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_TC0   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TC1   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TC2   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FIFO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd4;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_INTR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_SEQ   = 4'd7;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd8;
    localparam logic [ADDR_W-1:0] A_CFG1  = 4'd9;

    localparam logic [6:0] OP_NOP    = 7'h00;
    localparam logic [6:0] OP_FLUSH  = 7'h01;
    localparam logic [6:0] OP_RESET  = 7'h02;
    localparam logic [6:0] OP_BUSRST = 7'h03;
    localparam logic [6:0] OP_ICOMP  = 7'h11;
    localparam logic [6:0] OP_MSGACK = 7'h12;
    localparam logic [6:0] OP_PAD    = 7'h18;
    localparam logic [6:0] OP_SEL    = 7'h41;
    localparam logic [6:0] OP_SELA   = 7'h42;
    localparam logic [6:0] OP_SELAS  = 7'h43;
    localparam logic [6:0] OP_RSELON = 7'h44;
    localparam logic [6:0] OP_RSELOF = 7'h45;

    localparam logic [7:0] CAUSE_DONE = 8'h08;
    localparam logic [7:0] CAUSE_DISC = 8'h20;
    localparam logic [7:0] CAUSE_BRST = 8'h80;
    localparam logic [2:0] STEP_DONE  = 3'd4;
    localparam logic [2:0] PH_MSGIN   = 3'b111;
    localparam int         CFG_QUIET  = 6;
    localparam logic [7:0] CFG1_INIT  = 8'h07;

    typedef enum logic [1:0] {
        SEL_PLAIN = 2'd0,
        SEL_ATN   = 2'd1,
        SEL_STOP  = 2'd2
    } sel_kind_e;

    typedef struct packed {
        logic flush;
        logic reset;
        logic busrst;
        logic icomp;
        logic msgack;
        logic pad;
        logic sel;
        logic sela;
        logic selas;
        logic rsel;
    } cmd_dec_t;
endpackage

// File: rtl/scsi_cmd_decode.sv
// Command byte decoder: splits the DMA flag from the 7-bit code and flags
// each known command. Purely combinational; an unknown code gives known=0.
module scsi_cmd_decode
    import scsi_regs_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_dec_t   dec_o,
    output logic       known_o,
    output logic       dma_o
);
    logic [6:0] op;

    // Map the code field onto one flag per command.
    always_comb begin
        op            = code_i[6:0];
        dma_o         = code_i[7];
        dec_o         = '0;
        dec_o.flush   = (op == OP_FLUSH);
        dec_o.reset   = (op == OP_RESET);
        dec_o.busrst  = (op == OP_BUSRST);
        dec_o.icomp   = (op == OP_ICOMP);
        dec_o.msgack  = (op == OP_MSGACK);
        dec_o.pad     = (op == OP_PAD);
        dec_o.sel     = (op == OP_SEL);
        dec_o.sela    = (op == OP_SELA);
        dec_o.selas   = (op == OP_SELAS);
        dec_o.rsel    = (op == OP_RSELON) || (op == OP_RSELOF);
        known_o       = (|dec_o) || (op == OP_NOP);
    end
endmodule

// File: rtl/scsi_xfer_count.sv
// Transfer counter: a written load copy and a readable working copy per byte
// lane, with reload from the load copy. The top lane reads a fixed identity
// until it has been written. Assumes reload and lane writes never coincide.
module scsi_xfer_count
    import scsi_regs_pkg::*;
#(
    parameter int         LANES   = CNT_BYTES,
    parameter logic [7:0] CHIP_ID = 8'hA2,
    localparam int        LW      = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [LW-1:0]         lane_i,
    input  logic [7:0]            data_i,
    input  logic                  reload_i,
    output logic [LANES-1:0][7:0] view_o
);
    logic [LANES-1:0][7:0] load_q;
    logic [LANES-1:0][7:0] work_q;
    logic                  top_written_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold the load copy and the working copy for one byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                load_q[g] <= '0;
                work_q[g] <= '0;
            end else begin
                if (wr_i && (lane_i == LW'(g))) load_q[g] <= data_i;
                if (reload_i)                   work_q[g] <= load_q[g];
            end
        end
        if (g == LANES - 1) begin : g_top
            assign view_o[g] = top_written_q ? work_q[g] : CHIP_ID;
        end else begin : g_low
            assign view_o[g] = work_q[g];
        end
    end

    // Remember whether the top lane was written since hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                            top_written_q <= 1'b0;
        else if (wr_i && (lane_i == LW'(LANES - 1)))    top_written_q <= 1'b1;
    end

    // R3: a reload makes the working copy equal to the prior load copy.
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !clr_i) |=> (work_q == $past(load_q)));
endmodule

// File: rtl/scsi_irq_line.sv
// Interrupt line holder: set by a raise request, cleared by a lower request
// or a hard clear. Raise wins if both arrive together (they never do here).
module scsi_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic raise_i,
    input  logic lower_i,
    output logic irq_o
);
    // Track the pending-interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) irq_o <= 1'b0;
        else if (raise_i)    irq_o <= 1'b1;
        else if (lower_i)    irq_o <= 1'b0;
    end

    // R1: the line only rises after a raise request.
    assert_irq_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(raise_i));
    // R1: the line only falls after a lower request or hard clear.
    assert_irq_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(lower_i || clr_i));
endmodule

// File: rtl/scsi_cmd_regs.sv
// SCSI host adapter command/interrupt register front end. Decodes byte writes
// to the command register, keeps status, cause, sequence step, configuration
// and a FIFO fill count, and drives one level interrupt. Assumes software
// never asserts wr_en and rd_en in the same cycle; if it does, the write
// proceeds and the acknowledge side effect is skipped.
module scsi_cmd_regs
    import scsi_regs_pkg::*;
#(
    parameter int         FIFO_DEPTH = 16,
    parameter logic [7:0] CHIP_ID    = 8'hA2,
    localparam int        FCW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              irq,
    output logic              sel_start,
    output logic [1:0]        sel_mode
);
    cmd_dec_t                  dec;
    logic                      known, dma;
    logic                      cmd_go, hard_clr, ack_rd, raise, reload;
    logic [7:0]                cmd_q, cause_q, cfg1_q;
    logic                      stat_tc_q;
    logic [2:0]                phase_q, step_q;
    logic [FCW-1:0]            fifo_cnt_q;
    logic [CNT_BYTES-1:0][7:0] tc_view;

    scsi_cmd_decode u_dec (
        .code_i (wr_data),
        .dec_o  (dec),
        .known_o(known),
        .dma_o  (dma)
    );

    // Qualify the command write and derive the side-effect requests.
    always_comb begin
        cmd_go   = wr_en && (addr == A_CMD) && known;
        hard_clr = cmd_go && dec.reset;
        ack_rd   = rd_en && !wr_en && (addr == A_INTR);
        reload   = cmd_go && dma && !dec.reset;
        raise    = cmd_go && (dec.flush || dec.icomp || dec.msgack || dec.pad ||
                              (dec.busrst && !cfg1_q[CFG_QUIET]));
    end

    scsi_xfer_count #(.LANES(CNT_BYTES), .CHIP_ID(CHIP_ID)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (hard_clr),
        .wr_i    (wr_en && (addr <= A_TC2)),
        .lane_i  (addr[1:0]),
        .data_i  (wr_data),
        .reload_i(reload),
        .view_o  (tc_view)
    );

    scsi_irq_line u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hard_clr),
        .raise_i(raise),
        .lower_i(ack_rd),
        .irq_o  (irq)
    );

    // Update status, cause, step, config and FIFO count from writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) begin
            cmd_q      <= '0;
            cause_q    <= '0;
            cfg1_q     <= CFG1_INIT;
            stat_tc_q  <= 1'b0;
            phase_q    <= '0;
            step_q     <= '0;
            fifo_cnt_q <= '0;
        end else begin
            if (wr_en && (addr == A_CFG1)) cfg1_q <= wr_data;
            if (wr_en && (addr == A_FIFO) && (fifo_cnt_q != FCW'(FIFO_DEPTH)))
                fifo_cnt_q <= fifo_cnt_q + 1'b1;
            if (cmd_go) begin
                cmd_q <= wr_data;
                if (!dma) stat_tc_q <= 1'b0;
                if (dec.flush) begin
                    fifo_cnt_q <= '0;
                    cause_q    <= CAUSE_DONE;
                    step_q     <= '0;
                end
                if (dec.busrst) cause_q <= CAUSE_BRST;
                if (dec.icomp) begin
                    cause_q <= CAUSE_DONE;
                    phase_q <= PH_MSGIN;
                end
                if (dec.msgack) begin
                    cause_q    <= CAUSE_DISC;
                    step_q     <= '0;
                    fifo_cnt_q <= '0;
                end
                if (dec.pad) begin
                    stat_tc_q <= 1'b1;
                    phase_q   <= '0;
                    cause_q   <= CAUSE_DONE;
                    step_q    <= '0;
                end
                if (dec.rsel) cause_q <= '0;
            end
            if (ack_rd) begin
                cause_q   <= '0;
                stat_tc_q <= 1'b0;
                step_q    <= STEP_DONE;
            end
        end
    end

    // Issue the one-cycle selection strobe and hold the selection kind.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) begin
            sel_start <= 1'b0;
            sel_mode  <= SEL_PLAIN;
        end else begin
            sel_start <= cmd_go && (dec.sel || dec.sela || dec.selas);
            if (cmd_go && dec.sel)   sel_mode <= SEL_PLAIN;
            if (cmd_go && dec.sela)  sel_mode <= SEL_ATN;
            if (cmd_go && dec.selas) sel_mode <= SEL_STOP;
        end
    end

    // Select the read byte for the current address.
    always_comb begin
        case (addr)
            A_TC0:   rd_data = tc_view[0];
            A_TC1:   rd_data = tc_view[1];
            A_TC2:   rd_data = tc_view[2];
            A_CMD:   rd_data = cmd_q;
            A_STAT:  rd_data = {irq, 2'b00, stat_tc_q, 1'b0, phase_q};
            A_INTR:  rd_data = cause_q;
            A_SEQ:   rd_data = {5'd0, step_q};
            A_FLAGS: rd_data = 8'(fifo_cnt_q);
            A_CFG1:  rd_data = cfg1_q;
            default: rd_data = 8'h00;
        endcase
    end

    // R2: an acknowledge read leaves cause cleared, step done and line low.
    assert_ack_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (cause_q == 8'h00) && (step_q == STEP_DONE) && !irq && !stat_tc_q);
    // R6: a suppressed bus reset leaves the line where it was.
    assert_quiet_busrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && dec.busrst && cfg1_q[CFG_QUIET]) |=> $stable(irq));
    // R11: the strobe only follows a command-register write.
    assert_sel_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |-> $past(wr_en && (addr == A_CMD)));
    // R12: an unknown code leaves the visible registers alone.
    assert_unknown_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_CMD) && !known) |=>
            $stable(cmd_q) && $stable(cause_q) && $stable(step_q) &&
            $stable(stat_tc_q) && $stable(irq) && $stable(tc_view));
    // R13: the FIFO count never passes the depth.
    assert_fifo_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt_q <= FCW'(FIFO_DEPTH));
endmodule

// File: tb/scsi_cmd_regs_bench.sv
`timescale 1ns/1ps
module scsi_cmd_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq, sel_start;
    logic [1:0] sel_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scsi_cmd_regs u_scsi_cmd_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .sel_start(sel_start), .sel_mode(sel_mode)
    );

    // Behavioural reference state.
    int m_load[3], m_work[3];
    bit m_hw;
    int m_cfg1, m_cmd, m_tc, m_ph, m_int, m_cause, m_step, m_fifo, m_sel, m_mode;

    task automatic m_reset();
        for (int i = 0; i < 3; i++) begin m_load[i] = 0; m_work[i] = 0; end
        m_hw = 0; m_cfg1 = 7; m_cmd = 0; m_tc = 0; m_ph = 0; m_int = 0;
        m_cause = 0; m_step = 0; m_fifo = 0; m_sel = 0; m_mode = 0;
    endtask

    function automatic bit is_known(int op);
        return op inside {'h00, 'h01, 'h02, 'h03, 'h11, 'h12, 'h18,
                          'h41, 'h42, 'h43, 'h44, 'h45};
    endfunction

    task automatic m_step_fn(bit w, bit r, int a, int d);
        int op;
        bit dm;
        m_sel = 0;
        if (w) begin
            if (a <= 2) begin m_load[a] = d; if (a == 2) m_hw = 1; end
            else if (a == 3) begin if (m_fifo < 16) m_fifo++; end
            else if (a == 9) m_cfg1 = d;
            else if (a == 4) begin
                op = d & 'h7f; dm = d[7];
                if (is_known(op)) begin
                    if (op == 'h02) m_reset();
                    else begin
                        m_cmd = d;
                        if (dm) for (int i = 0; i < 3; i++) m_work[i] = m_load[i];
                        else m_tc = 0;
                        case (op)
                            'h01: begin m_fifo = 0; m_cause = 'h08; m_step = 0; m_int = 1; end
                            'h03: begin m_cause = 'h80; if (!m_cfg1[6]) m_int = 1; end
                            'h11: begin m_cause = 'h08; m_ph = 7; m_int = 1; end
                            'h12: begin m_cause = 'h20; m_step = 0; m_fifo = 0; m_int = 1; end
                            'h18: begin m_tc = 1; m_ph = 0; m_cause = 'h08; m_step = 0; m_int = 1; end
                            'h41: begin m_sel = 1; m_mode = 0; end
                            'h42: begin m_sel = 1; m_mode = 1; end
                            'h43: begin m_sel = 1; m_mode = 2; end
                            'h44, 'h45: m_cause = 0;
                            default: ;
                        endcase
                    end
                end
            end
        end else if (r && a == 6) begin
            m_cause = 0; m_tc = 0; m_step = 4; m_int = 0;
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return m_work[0];
            1: return m_work[1];
            2: return m_hw ? m_work[2] : 'hA2;
            4: return m_cmd;
            5: return (m_int << 7) | (m_tc << 4) | m_ph;
            6: return m_cause;
            7: return m_step;
            8: return m_fifo;
            9: return m_cfg1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check before and after the rising edge.
    task automatic cyc(bit rst, bit w, bit r, int a, int d, string tag);
        rst_n = !rst; wr_en = w; rd_en = r; addr = 4'(a); wr_data = 8'(d);
        #1;
        if (!rst) chk({tag, " read before edge"}, int'(rd_data), m_read(a));
        @(posedge clk);
        if (rst) m_reset(); else m_step_fn(w, r, a, d);
        @(negedge clk);
        chk({tag, " read"}, int'(rd_data), m_read(a));
        chk({tag, " R1 irq"}, int'(irq), m_int);
        chk({tag, " R11 sel_start"}, int'(sel_start), m_sel);
        chk({tag, " R11 sel_mode"}, int'(sel_mode), m_mode);
    endtask

    task automatic wr(int a, int d, string tag); cyc(0, 1, 0, a, d, tag); endtask
    task automatic peek(int a, string tag);     cyc(0, 0, 0, a, 0, tag); endtask
    task automatic ack(string tag);             cyc(0, 0, 1, 6, 0, tag); endtask
    task automatic sweep(string tag);
        for (int a = 0; a < 12; a++) peek(a, tag);
    endtask

    initial begin
        m_reset();
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 9, 0, "R10 reset");
        sweep("R10 reset state");
        peek(2, "R4 identity after reset");

        for (int i = 0; i < 3; i++) wr(3, i, "R13 fifo write");
        peek(8, "R13 fifo count 3");
        for (int i = 0; i < 18; i++) wr(3, i, "R13 fifo saturate");
        peek(8, "R13 fifo count 16");

        wr(4, 'h01, "R5 flush");
        sweep("R5 after flush");
        ack("R2 ack read");
        sweep("R2 after ack");

        wr(0, 'h11, "R3 load low"); wr(1, 'h22, "R3 load mid"); wr(2, 'h33, "R3 load high");
        sweep("R3 no reload yet R4");
        wr(4, 'h80, "R3 nop with DMA");
        sweep("R3 after reload");

        wr(4, 'h18, "R9 pad");
        peek(5, "R9 status 0x90"); peek(6, "R9 cause"); peek(7, "R9 step");
        wr(4, 'h00, "R3 nop clears tc");
        peek(5, "R3 status after nop");
        ack("R2 ack after pad");

        wr(4, 'h03, "R6 bus reset");
        peek(6, "R6 cause"); ack("R2 ack after bus reset");
        wr(9, 'h47, "R6 set quiet");
        wr(4, 'h03, "R6 quiet bus reset");
        peek(6, "R6 quiet cause"); peek(5, "R6 quiet irq low");
        wr(4, 'h18, "R9 pad pending");
        wr(4, 'h03, "R6 quiet bus reset while pending");
        peek(5, "R6 pending held");
        ack("R2 ack");

        wr(4, 'h11, "R7 initiator complete");
        peek(5, "R7 status phase"); peek(6, "R7 cause");
        for (int i = 0; i < 4; i++) wr(3, i, "R13 fifo refill");
        wr(4, 'h12, "R8 message accept");
        sweep("R8 after accept");

        wr(4, 'h44, "R11 reselect enable");
        peek(6, "R11 cause cleared"); peek(5, "R11 irq kept");
        wr(4, 'h92, "R8 accept with DMA");
        wr(4, 'h45, "R11 reselect disable");
        peek(6, "R11 cause cleared again");
        ack("R2 ack");

        wr(4, 'h42, "R11 select atn");
        peek(4, "R11 idle after strobe");
        wr(4, 'h41, "R11 select plain");
        wr(4, 'h43, "R11 select stop");
        wr(4, 'hC3, "R11 select stop back to back");
        peek(4, "R11 strobe ends");

        wr(4, 'h18, "R12 prepare");
        wr(0, 'h55, "R12 load low");
        wr(4, 'hFF, "R12 unknown with DMA");
        sweep("R12 unchanged");
        wr(4, 'h20, "R12 unknown plain");
        sweep("R12 unchanged plain");

        wr(9, 'h00, "R10 config change");
        wr(4, 'h02, "R10 chip reset");
        sweep("R10 after chip reset R4");
        wr(2, 'h00, "R4 write high");
        peek(2, "R4 written high reads work");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule